// File: doc/BRIEF.md
# Timer interrupt flag register

This block keeps the pending-interrupt flags of a 16-bit timer/counter in one 8-bit status register that the CPU can read. The counter side feeds it strobes: a capture-pin event, a TOP-reached strobe, two compare-match strobes with their force strobes, an overflow strobe, and the waveform-mode code. Counter events count only in cycles where the prescaler tick is high. The CPU side reads the register, clears flags by writing ones, and acknowledges taken vectors one flag at a time. A flag ANDed with its enable bit gives an interrupt request.

Each flag is a two-state machine with the states FLAG_IDLE and FLAG_PENDING. The transition FLAG_IDLE to FLAG_PENDING, named *raise*, happens on a qualified hardware set. The transition FLAG_PENDING to FLAG_IDLE, named *drop*, happens on a write-one or an acknowledge with no set in the same cycle. Otherwise the state holds. A small mode decode chooses the source of the capture flag. It also decides whether the overflow strobe may raise the overflow flag.

Top module: `tmr_irq_flags`

## Requirements
- R1: After reset every bit of `rd_data` reads zero. The register layout is capture flag at bit 5, compare-B flag at bit 2, compare-A flag at bit 1 and overflow flag at bit 0. Bits 7, 6, 4 and 3 always read zero.
- R2: When `wgm` is not 8, 10, 12 or 14, a ticked `cap_pin_evt` sets bit 5 at the next clock edge, and `top_hit` has no effect on bit 5.
- R3: When `wgm` is 8, 10, 12 or 14, the capture register defines TOP. A ticked `top_hit` then sets bit 5 and `cap_pin_evt` is ignored.
- R4: A compare match strobe seen on a ticked cycle sets its flag (A to bit 1, B to bit 2) at the edge of the next ticked cycle, not at the edge where it was seen.
- R5: A compare match strobe that comes in the same ticked cycle as that channel's force strobe never sets the flag.
- R6: A ticked `ovf_hit` sets bit 0 only when `wgm` is 0 or 4. In every other mode it is ignored.
- R7: A CPU write clears each flag whose bit position in `wr_data` is one. Zero bits leave their flag unchanged, and writes to reserved bits have no effect.
- R8: A one-cycle `ack` bit clears its flag. The `ack`, `irq_en` and `irq` vectors share one order: bit 3 capture, bit 2 compare-B, bit 1 compare-A, bit 0 overflow.
- R9: When a hardware set and a clear (write-one or acknowledge) reach one flag in the same cycle, the flag ends set.
- R10: While `tick` is low no flag can become set, and a match seen then is not remembered. Writes and acknowledges act whether or not `tick` is high.
- R11: Each `irq` bit equals its flag ANDed with the matching `irq_en` bit.
- R12: Reset also discards a compare match that is waiting for its one-tick delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer clock enable (prescaler tick) |
| cap_pin_evt | input | 1 | Capture-pin event strobe |
| top_hit | input | 1 | Counter reached TOP strobe |
| cmp_a_hit | input | 1 | Compare A match strobe |
| cmp_b_hit | input | 1 | Compare B match strobe |
| force_a | input | 1 | Forced compare strobe, channel A |
| force_b | input | 1 | Forced compare strobe, channel B |
| ovf_hit | input | 1 | Counter overflow strobe |
| wgm | input | WGM_W | Waveform-mode code |
| wr_en | input | 1 | CPU write strobe for the flag register |
| wr_data | input | 8 | CPU write data (ones clear flags) |
| ack | input | 4 | Per-flag vector-taken acknowledge |
| irq_en | input | 4 | Per-flag interrupt enable |
| rd_data | output | 8 | Register read value |
| irq | output | 4 | Per-flag interrupt requests |

## Verification
A hardware set and a clear can reach the same flag in one cycle. The clear may be a CPU write-one or a vector acknowledge. The bench provokes this in two ways. It raises a delayed compare-A set in the same cycle as a write that clears bit 1. It also presents a ticked overflow strobe together with the overflow acknowledge. In both cases the flag must read set on the next sample, and the other flags must be untouched. The bench also checks the reverse case: a clear with no set present must bring the flag back to zero.

// File: rtl/tmr_flag_pkg.sv
package tmr_flag_pkg;

    localparam int REG_W     = 8;
    localparam int NUM_FLAGS = 4;

    // flag indices, also the bit order of ack / irq_en / irq
    localparam int FLG_OVF  = 0;
    localparam int FLG_CMPA = 1;
    localparam int FLG_CMPB = 2;
    localparam int FLG_CAP  = 3;

    localparam logic [REG_W-1:0] FLAG_MASK = 8'h27;

    typedef enum logic {
        FLAG_IDLE    = 1'b0,
        FLAG_PENDING = 1'b1
    } flag_state_e;

    // register bit position of each flag index
    function automatic int flag_bit(input int idx);
        case (idx)
            FLG_OVF:  return 0;
            FLG_CMPA: return 1;
            FLG_CMPB: return 2;
            default:  return 5;
        endcase
    endfunction

endpackage

// File: rtl/tmr_mode_dec.sv
module tmr_mode_dec #(
    parameter int WGM_W = 4
) (
    input  logic [WGM_W-1:0] wgm,
    output logic             cap_is_top,
    output logic             ovf_direct
);

    always_comb begin
        cap_is_top = (wgm == WGM_W'(8))  || (wgm == WGM_W'(10)) ||
                     (wgm == WGM_W'(12)) || (wgm == WGM_W'(14));
        ovf_direct = (wgm == WGM_W'(0))  || (wgm == WGM_W'(4));
    end

endmodule

// File: rtl/tmr_cmp_delay.sv
module tmr_cmp_delay #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hit,
    input  logic force_s,
    output logic set_o
);

    logic              hit_q;
    logic [STAGES-1:0] pipe_q;

    assign hit_q = hit & ~force_s;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n)    pipe_q <= '0;
                else if (tick) pipe_q <= hit_q;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n)    pipe_q <= '0;
                else if (tick) pipe_q <= {pipe_q[STAGES-2:0], hit_q};
            end
        end
    endgenerate

    assign set_o = tick & pipe_q[STAGES-1];

    // R4: an unforced ticked match enters the delay line
    a_r4_match_captured: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && hit && !force_s) |=> pipe_q[0]);

    // R5: a forced match is never stored
    a_r5_force_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && force_s) |=> !pipe_q[0]);

    // R10: held state does not move without a tick
    a_r10_pipe_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(pipe_q));

endmodule

// File: rtl/tmr_flag_cell.sv
module tmr_flag_cell
    import tmr_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    flag_state_e state_q;
    flag_state_e state_d;

    // next-state: raise on set, drop on clear unless set present
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: begin
                if (set_i) state_d = FLAG_PENDING;
            end
            FLAG_PENDING: begin
                if (clr_i && !set_i) state_d = FLAG_IDLE;
            end
            default: state_d = FLAG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    // output process
    always_comb begin
        flag_o = (state_q == FLAG_PENDING);
    end

    // R9: a set in the same cycle as a clear leaves the flag set
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    // R7, R8: a clear with no set empties the flag
    a_r7_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);

    a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !flag_o) |=> !flag_o);

endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
    import tmr_flag_pkg::*;
#(
    parameter int WGM_W      = 4,
    parameter int CMP_STAGES = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 cap_pin_evt,
    input  logic                 top_hit,
    input  logic                 cmp_a_hit,
    input  logic                 cmp_b_hit,
    input  logic                 force_a,
    input  logic                 force_b,
    input  logic                 ovf_hit,
    input  logic [WGM_W-1:0]     wgm,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_data,
    input  logic [NUM_FLAGS-1:0] ack,
    input  logic [NUM_FLAGS-1:0] irq_en,
    output logic [REG_W-1:0]     rd_data,
    output logic [NUM_FLAGS-1:0] irq
);

    logic                 cap_is_top;
    logic                 ovf_direct;
    logic                 set_cmpa;
    logic                 set_cmpb;
    logic [NUM_FLAGS-1:0] set_v;
    logic [NUM_FLAGS-1:0] clr_v;
    logic [NUM_FLAGS-1:0] flags;

    tmr_mode_dec #(.WGM_W(WGM_W)) u_mode (
        .wgm        (wgm),
        .cap_is_top (cap_is_top),
        .ovf_direct (ovf_direct)
    );

    tmr_cmp_delay #(.STAGES(CMP_STAGES)) u_dly_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .hit     (cmp_a_hit),
        .force_s (force_a),
        .set_o   (set_cmpa)
    );

    tmr_cmp_delay #(.STAGES(CMP_STAGES)) u_dly_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .hit     (cmp_b_hit),
        .force_s (force_b),
        .set_o   (set_cmpb)
    );

    always_comb begin
        set_v           = '0;
        set_v[FLG_CAP]  = tick & (cap_is_top ? top_hit : cap_pin_evt);
        set_v[FLG_CMPB] = set_cmpb;
        set_v[FLG_CMPA] = set_cmpa;
        set_v[FLG_OVF]  = tick & ovf_hit & ovf_direct;
    end

    always_comb begin
        for (int i = 0; i < NUM_FLAGS; i++) begin
            clr_v[i] = ack[i] | (wr_en & wr_data[flag_bit(i)]);
        end
    end

    generate
        for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
            tmr_flag_cell u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (set_v[g]),
                .clr_i  (clr_v[g]),
                .flag_o (flags[g])
            );
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_FLAGS; i++) begin
            rd_data[flag_bit(i)] = flags[i];
        end
    end

    assign irq = flags & irq_en;

    // R10: without a tick no flag rises
    a_r10_no_tick_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ((flags & ~$past(flags)) == '0));

    // R6: overflow strobe ignored outside the direct modes
    a_r6_ovf_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_direct && !flags[FLG_OVF]) |=> !flags[FLG_OVF]);

    // R3: in TOP-from-capture modes the pin event alone does nothing
    a_r3_pin_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_is_top && !top_hit && !flags[FLG_CAP]) |=> !flags[FLG_CAP]);

    // R7: a write touching only reserved bits, with no set or ack, changes nothing
    a_r7_rsvd_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ((wr_data & FLAG_MASK) == '0) && (ack == '0) && (set_v == '0))
        |=> (rd_data == $past(rd_data)));

endmodule

// File: tb/tmr_irq_flags_tb.sv
module tmr_irq_flags_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick, cap_pin_evt, top_hit, cmp_a_hit, cmp_b_hit;
    logic       force_a, force_b, ovf_hit, wr_en;
    logic [3:0] wgm;
    logic [7:0] wr_data;
    logic [3:0] ack, irq_en;
    logic [7:0] rd_data;
    logic [3:0] irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    tmr_irq_flags u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cap_pin_evt(cap_pin_evt),
        .top_hit(top_hit), .cmp_a_hit(cmp_a_hit), .cmp_b_hit(cmp_b_hit),
        .force_a(force_a), .force_b(force_b), .ovf_hit(ovf_hit), .wgm(wgm),
        .wr_en(wr_en), .wr_data(wr_data), .ack(ack), .irq_en(irq_en),
        .rd_data(rd_data), .irq(irq)
    );

    typedef struct packed {
        logic       tk, cap, top, ma, mb, fa, fb, ov;
        logic [3:0] wgm;
        logic       we;
        logic [7:0] wd;
        logic [3:0] ack;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [0:NV-1] = '{
        '{1,0,0,0,0,0,0,1, 4'd0, 0,8'h00,4'h0, 8'h01, 4'd6},  // R6 normal ovf
        '{1,0,0,1,0,0,0,0, 4'd0, 0,8'h00,4'h0, 8'h01, 4'd4},  // R4 match seen
        '{1,0,0,0,0,0,0,0, 4'd0, 0,8'h00,4'h0, 8'h03, 4'd4},  // R4 A sets next tick
        '{0,0,0,0,1,0,0,0, 4'd0, 0,8'h00,4'h0, 8'h03, 4'd10}, // R10 no tick
        '{1,0,0,0,0,0,0,0, 4'd0, 0,8'h00,4'h0, 8'h03, 4'd10}, // R10 not remembered
        '{0,0,0,0,0,0,0,0, 4'd0, 1,8'h01,4'h0, 8'h02, 4'd7},  // R7 clear ovf
        '{1,1,0,0,0,0,0,0, 4'd0, 0,8'h00,4'h0, 8'h22, 4'd2},  // R2 pin
        '{0,0,0,0,0,0,0,0, 4'd0, 0,8'h00,4'h8, 8'h02, 4'd8},  // R8 ack cap
        '{1,0,0,0,1,0,1,0, 4'd0, 0,8'h00,4'h0, 8'h02, 4'd5},  // R5 forced B
        '{1,0,0,0,0,0,0,0, 4'd0, 0,8'h00,4'h0, 8'h02, 4'd5},  // R5 no late set
        '{1,1,0,0,0,0,0,0, 4'd12,0,8'h00,4'h0, 8'h02, 4'd3},  // R3 pin ignored
        '{1,0,1,0,0,0,0,0, 4'd12,0,8'h00,4'h0, 8'h22, 4'd3},  // R3 top sets
        '{1,0,1,0,0,0,0,0, 4'd0, 0,8'h00,4'h0, 8'h22, 4'd2},  // R2 top ignored
        '{1,0,0,0,0,0,0,1, 4'd8, 0,8'h00,4'h0, 8'h22, 4'd6},  // R6 pwm ovf ignored
        '{1,0,0,0,0,0,0,1, 4'd4, 0,8'h00,4'h0, 8'h23, 4'd6},  // R6 ctc ovf
        '{0,0,0,0,0,0,0,0, 4'd0, 1,8'hFF,4'h0, 8'h00, 4'd7},  // R7 clear all
        '{1,0,0,1,0,0,0,0, 4'd0, 0,8'h00,4'h0, 8'h00, 4'd4},  // R4 match seen
        '{1,0,0,0,0,0,0,0, 4'd0, 1,8'h02,4'h0, 8'h02, 4'd9},  // R9 set beats write
        '{1,0,0,0,0,0,0,1, 4'd0, 0,8'h00,4'h1, 8'h03, 4'd9},  // R9 set beats ack
        '{0,0,0,0,0,0,0,0, 4'd0, 1,8'hDC,4'h0, 8'h03, 4'd7},  // R7 zeros keep
        '{0,0,0,0,0,0,0,0, 4'd0, 0,8'h00,4'h2, 8'h01, 4'd8},  // R8 ack A
        '{0,0,0,0,0,0,0,0, 4'd0, 0,8'h00,4'h1, 8'h00, 4'd8},  // R8 ack ovf
        '{1,0,0,0,0,0,0,1, 4'd0, 0,8'h00,4'h0, 8'h01, 4'd6},  // R6 ovf again
        '{0,0,0,0,0,0,0,0, 4'd0, 1,8'h00,4'h0, 8'h01, 4'd7},  // R7 zero write
        '{1,0,0,1,0,1,0,0, 4'd0, 0,8'h00,4'h0, 8'h01, 4'd5},  // R5 forced A
        '{1,0,0,0,0,0,0,0, 4'd0, 0,8'h00,4'h0, 8'h01, 4'd5},  // R5 no late set
        '{0,0,0,0,0,0,0,0, 4'd0, 1,8'hD8,4'h0, 8'h01, 4'd7},  // R7 reserved write
        '{0,0,0,0,0,0,0,0, 4'd0, 0,8'h00,4'h1, 8'h00, 4'd8}   // R8 ack ovf
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        tick = 0; cap_pin_evt = 0; top_hit = 0; cmp_a_hit = 0; cmp_b_hit = 0;
        force_a = 0; force_b = 0; ovf_hit = 0; wgm = 4'd0;
        wr_en = 0; wr_data = 8'h00; ack = 4'h0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        idle();
        irq_en = 4'hF;
        rst_n  = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset read", rd_data, 8'h00);
        check("R1 reset irq", {4'h0, irq}, 8'h00);

        // table walk
        for (int i = 0; i < NV; i++) begin
            tick = VECS[i].tk; cap_pin_evt = VECS[i].cap; top_hit = VECS[i].top;
            cmp_a_hit = VECS[i].ma; cmp_b_hit = VECS[i].mb;
            force_a = VECS[i].fa; force_b = VECS[i].fb; ovf_hit = VECS[i].ov;
            wgm = VECS[i].wgm; wr_en = VECS[i].we; wr_data = VECS[i].wd;
            ack = VECS[i].ack;
            @(negedge clk);
            check($sformatf("R%0d vec %0d", VECS[i].req, i), rd_data, VECS[i].exp);
            check($sformatf("R11 vec %0d", i), {4'h0, irq},
                  {4'h0, VECS[i].exp[5], VECS[i].exp[2], VECS[i].exp[1], VECS[i].exp[0]});
        end
        idle();

        // R11: enable gating with all flags set
        tick = 1; cap_pin_evt = 1; ovf_hit = 1; cmp_a_hit = 1; cmp_b_hit = 1;
        @(negedge clk);
        idle(); tick = 1;
        @(negedge clk);
        idle();
        check("R1 layout all set", rd_data, 8'h27);
        irq_en = 4'b1010;
        #1 check("R11 mask 1010", {4'h0, irq}, 8'h0A);
        irq_en = 4'b0101;
        #1 check("R11 mask 0101", {4'h0, irq}, 8'h05);
        irq_en = 4'b0000;
        #1 check("R11 mask none", {4'h0, irq}, 8'h00);
        irq_en = 4'hF;

        // R1: reset clears set flags
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        check("R1 reset mid-run", rd_data, 8'h00);

        // R12: reset drops a pending compare
        tick = 1; cmp_b_hit = 1;
        @(negedge clk);
        idle();
        rst_n = 0;
        @(negedge clk);
        rst_n = 1; tick = 1;
        @(negedge clk);
        idle();
        check("R12 pending dropped", rd_data, 8'h00);

        // R4 with idle gap: match, no ticks, flag only on next tick
        tick = 1; cmp_b_hit = 1;
        @(negedge clk);
        idle();
        @(negedge clk);
        @(negedge clk);
        check("R4 waits for tick", rd_data, 8'h00);
        tick = 1;
        @(negedge clk);
        idle();
        check("R4 sets on next tick", rd_data, 8'h04);

        done = 1'b1;
        finish_run();
    end

endmodule